// File: doc/BRIEF.md
# Windowed Byte FIFO with Low-Level Interrupt

This block is a byte queue whose storage is a window carved out of a shared local RAM. Two runtime inputs, each counted in 8-byte units, set where the window lies. The start unit is the first unit of the queue. The end unit is the first unit past it. The CPU side writes bytes in bursts and is told at the end of each burst how many of them were kept. It can also read the number of bytes held and the number of bytes still free. The bus side takes one byte off the head of the queue each time the external master reads the queue address. That decode happens outside the block and arrives here as a one-cycle pop strobe.

Four sticky status flags report events, and the CPU clears each one by writing a one to it:
- the level fell below a programmed byte mark;
- a byte was written while the queue was full;
- a pop was made on an empty queue;
- a pop was made while the window had no size.

A CPU clear request empties the queue. Read and write positions are kept as offsets into the window. Each offset wraps from the last byte of the window back to its first byte.

A four-state sequencer runs the CPU side:
- **IDLE**: waiting, and ready for a byte.
- **FILL**: inside a burst, and ready for a byte.
- **REPORT**: a one-cycle state that presents the accepted count. Bytes offered here are not taken.
- **FLUSH**: a one-cycle state that resets the offsets and the level. Bytes and pops offered here are not taken.

The sequencer has these transitions:
- *start* goes from IDLE to FILL, on a byte without the last marker.
- *single* goes from IDLE to REPORT, on a byte with the last marker.
- *finish* goes from FILL to REPORT, on a byte with the last marker.
- *back* goes from REPORT to IDLE.
- *purge* goes from IDLE, FILL or REPORT to FLUSH, on a clear request.
- *resume* goes from FLUSH to IDLE.

Top module: `lram_fifo`

## Requirements
- R1: After reset the level is 0, all four status flags are 0, the write-ready output is 1 and the done pulse is 0.
- R2: The window size in bytes is 8 × (end unit − start unit) when the end unit is greater than the start unit, and 0 otherwise. An end unit above the RAM size is clamped to it. The used count equals the level, the free count equals size − level, and bytes leave in the order they were written.
- R3: With a window smaller than the traffic, repeated fill and drain cycles wrap the offsets and keep the write order intact across every wrap.
- R4: A byte written while level equals size is discarded and sets status bit 1 (overflow). The level and the later pop data do not change because of it.
- R5: A pop while the level is 0 and the size is nonzero returns 0x00, sets status bit 2 (underflow) and leaves the level at 0.
- R6: A pop while the size is 0 returns 0x00, sets status bit 3 (read error) and does not set bit 2.
- R7: Status bit 0 (low level) is set in the cycle in which the level goes from at least the mark to below it. A level that stays below the mark does not set it again. A level that rises does not set it.
- R8: A one on a bit of the clear input clears that status bit in the next cycle. A set event in the same cycle wins over the clear. A bit that is not cleared stays set.
- R9: A byte with the last marker ends a burst. In the next cycle the done output is 1 for one cycle, the count output equals the number of bytes of the burst that were kept, and write-ready is 0. A byte offered in that cycle is not taken.
- R10: A clear request makes the next cycle a flush cycle, with write-ready at 0 and the byte input not taken. After that cycle the level is 0 and the free count equals the size. A drop from at least the mark to 0 caused by the flush sets status bit 0.
- R11: A write and a pop in the same cycle both act. Both are judged against the level at the start of the cycle. On a partly filled queue the level is unchanged and the oldest byte is returned. On a full queue the byte is dropped with overflow and the level falls by one. On an empty queue the pop gives underflow and 0x00, and the byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fifo_base | input | 6 | First 8-byte unit of the window |
| cfg_ram_base | input | 6 | First 8-byte unit past the window |
| cfg_low_mark | input | 9 | Byte level below which the low flag sets |
| cpu_push_valid | input | 1 | CPU offers a byte this cycle |
| cpu_push_last | input | 1 | Offered byte ends the burst |
| cpu_push_data | input | 8 | Offered byte |
| cpu_push_ready | output | 1 | Sequencer can take a byte (IDLE or FILL) |
| cpu_push_done | output | 1 | One-cycle end-of-burst pulse |
| cpu_push_count | output | 9 | Bytes kept in the burst just finished |
| cpu_clear_req | input | 1 | Request to empty the queue |
| cpu_used | output | 9 | Bytes held |
| cpu_free | output | 9 | Bytes still free in the window |
| bus_pop | input | 1 | One-cycle strobe for a read of the queue address |
| bus_rd_data | output | 8 | Popped byte, valid the cycle after the strobe |
| irq_status | output | 4 | Flags: 0 low level, 1 overflow, 2 underflow, 3 read error |
| irq_clear | input | 4 | Write-one-to-clear per flag |

## Verification
A CPU write and a bus pop can land in the same cycle. The level, the accepted count and the flags must then all follow from the level held before that cycle. The bench drives both strobes on one edge in three cases: with two bytes held, with the window full, and with it empty. It then checks the returned byte, the used count and the overflow and underflow bits against what that pre-cycle level predicts. A pop with a clear of the low flag in the same cycle is also provoked. It is judged by the flag remaining set.

// File: rtl/lram_fifo_pkg.sv
package lram_fifo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_REPORT = 2'd2,
        ST_FLUSH  = 2'd3
    } fill_state_e;

    localparam int FL_LOW   = 0;
    localparam int FL_OVER  = 1;
    localparam int FL_UNDER = 2;
    localparam int FL_RDERR = 3;
    localparam int FL_NUM   = 4;

endpackage

// File: rtl/lram_fifo_mem.sv
module lram_fifo_mem #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/lram_fifo_ptr.sv
module lram_fifo_ptr #(
    parameter int RAM_BYTES  = 256,
    parameter int UNIT_BYTES = 8,
    parameter int AW         = 8,
    parameter int UW         = 6,
    parameter int CW         = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [UW-1:0] fifo_base,
    input  logic [UW-1:0] ram_base,
    input  logic          push_take,
    input  logic          pop_req,
    input  logic          flush,
    output logic [CW-1:0] size_o,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] count_nxt_o,
    output logic          push_ok_o,
    output logic          ovf_ev_o,
    output logic          udf_ev_o,
    output logic          rde_ev_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          pop_ok_q_o
);

    localparam int UNITS = RAM_BYTES / UNIT_BYTES;
    localparam int UB    = $clog2(UNIT_BYTES);

    logic [UW-1:0] rb_eff;
    logic [CW-1:0] size, base_addr;
    logic [CW-1:0] wr_off, rd_off, wr_off_inc, rd_off_inc;
    logic [CW-1:0] count_q, count_nxt;
    logic          full, empty, live;
    logic          push_ok, pop_ok, pop_ok_q;

    // window geometry
    always_comb begin
        rb_eff    = (ram_base > UW'(UNITS)) ? UW'(UNITS) : ram_base;
        size      = (rb_eff > fifo_base) ? (CW'(rb_eff - fifo_base) << UB) : '0;
        base_addr = CW'(fifo_base) << UB;
    end

    // event decode against the level at the start of the cycle
    always_comb begin
        live     = !flush;
        full     = (count_q >= size);
        empty    = (count_q == '0);
        push_ok  = live && push_take && !full;
        ovf_ev_o = live && push_take && full;
        pop_ok   = live && pop_req && (size != '0) && !empty;
        udf_ev_o = live && pop_req && (size != '0) && empty;
        rde_ev_o = live && pop_req && (size == '0);
    end

    // offsets wrap from the last byte of the window to its first
    always_comb begin
        wr_off_inc = ((wr_off + CW'(1)) >= size) ? '0 : wr_off + CW'(1);
        rd_off_inc = ((rd_off + CW'(1)) >= size) ? '0 : rd_off + CW'(1);
    end

    always_comb begin
        if (flush) begin
            count_nxt = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count_nxt = count_q + CW'(1);
                2'b01:   count_nxt = count_q - CW'(1);
                default: count_nxt = count_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_off   <= '0;
            rd_off   <= '0;
            count_q  <= '0;
            pop_ok_q <= 1'b0;
        end else begin
            count_q  <= count_nxt;
            pop_ok_q <= pop_ok;
            if (flush) begin
                wr_off <= '0;
                rd_off <= '0;
            end else begin
                if (push_ok) begin
                    wr_off <= wr_off_inc;
                end
                if (pop_ok) begin
                    rd_off <= rd_off_inc;
                end
            end
        end
    end

    always_comb begin
        size_o      = size;
        count_o     = count_q;
        count_nxt_o = count_nxt;
        push_ok_o   = push_ok;
        wr_en_o     = push_ok;
        wr_addr_o   = AW'(base_addr + wr_off);
        rd_en_o     = pop_ok;
        rd_addr_o   = AW'(base_addr + rd_off);
        pop_ok_q_o  = pop_ok_q;
    end

    // R11: a kept write and a pop together leave the level where it was
    p_pair_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> (count_q == $past(count_q)));

    // R4: a dropped byte does not move the level
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_ev_o && !pop_req) |=> $stable(count_q));

    // R5: a pop on an empty queue does not move the level
    p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_ev_o && !push_take) |=> $stable(count_q));

    // R3: every RAM access stays inside the window
    p_window_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((CW'(wr_addr_o) >= base_addr) && (CW'(wr_addr_o) < base_addr + size)));
    p_window_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> ((CW'(rd_addr_o) >= base_addr) && (CW'(rd_addr_o) < base_addr + size)));

endmodule

// File: rtl/lram_fifo_irq.sv
module lram_fifo_irq
    import lram_fifo_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count_q,
    input  logic [CW-1:0]     count_nxt,
    input  logic [CW-1:0]     low_mark,
    input  logic              ovf_ev,
    input  logic              udf_ev,
    input  logic              rde_ev,
    input  logic [FL_NUM-1:0] clr_w1,
    output logic [FL_NUM-1:0] status_o
);

    logic [FL_NUM-1:0] set_v;
    logic [FL_NUM-1:0] status_q;

    always_comb begin
        set_v           = '0;
        set_v[FL_LOW]   = (count_q >= low_mark) && (count_nxt < low_mark);
        set_v[FL_OVER]  = ovf_ev;
        set_v[FL_UNDER] = udf_ev;
        set_v[FL_RDERR] = rde_ev;
    end

    for (genvar i = 0; i < FL_NUM; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else begin
                status_q[i] <= set_v[i] | (status_q[i] & ~clr_w1[i]);
            end
        end

        // R8: write-one clears when no set event competes
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w1[i] && !set_v[i]) |=> !status_q[i]);

        // R8: an uncleared flag holds
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !clr_w1[i]) |=> status_q[i]);
    end

    // R7: downward crossing of the mark raises the low flag
    p_low_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_q >= low_mark) && (count_nxt < low_mark)) |=> status_q[FL_LOW]);

    assign status_o = status_q;

endmodule

// File: rtl/lram_fifo_seq.sv
module lram_fifo_seq
    import lram_fifo_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic          push_last,
    input  logic          clr_req,
    input  logic          push_ok,
    output logic          push_take_o,
    output logic          push_ready_o,
    output logic          flush_o,
    output logic          done_o,
    output logic [CW-1:0] acc_o
);

    fill_state_e st_q, st_d;
    logic [CW-1:0] acc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (clr_req) begin
                    st_d = ST_FLUSH;
                end else if (push_valid) begin
                    st_d = push_last ? ST_REPORT : ST_FILL;
                end
            end
            ST_FILL: begin
                if (clr_req) begin
                    st_d = ST_FLUSH;
                end else if (push_valid && push_last) begin
                    st_d = ST_REPORT;
                end
            end
            ST_REPORT: st_d = clr_req ? ST_FLUSH : ST_IDLE;
            ST_FLUSH:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push_ready_o = (st_q == ST_IDLE) || (st_q == ST_FILL);
        push_take_o  = push_ready_o && push_valid && !clr_req;
        flush_o      = (st_q == ST_FLUSH);
        done_o       = (st_q == ST_REPORT);
        acc_o        = acc_q;
    end

    // kept-byte counter for the current burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (push_take_o) begin
            acc_q <= ((st_q == ST_IDLE) ? '0 : acc_q) + CW'(push_ok);
        end
    end

    // R9: done lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a taken last byte is followed by the report
    p_last_reports_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_take_o && push_last) |=> done_o);

    // R10: a clear request leads into the flush cycle
    p_clear_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && (st_q != ST_FLUSH)) |=> (st_q == ST_FLUSH));

endmodule

// File: rtl/lram_fifo.sv
module lram_fifo
    import lram_fifo_pkg::*;
#(
    parameter int RAM_BYTES  = 256,
    parameter int UNIT_BYTES = 8,
    parameter int DW         = 8,
    localparam int AW        = $clog2(RAM_BYTES),
    localparam int UW        = $clog2(RAM_BYTES / UNIT_BYTES + 1),
    localparam int CW        = $clog2(RAM_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UW-1:0]     cfg_fifo_base,
    input  logic [UW-1:0]     cfg_ram_base,
    input  logic [CW-1:0]     cfg_low_mark,
    input  logic              cpu_push_valid,
    input  logic              cpu_push_last,
    input  logic [DW-1:0]     cpu_push_data,
    output logic              cpu_push_ready,
    output logic              cpu_push_done,
    output logic [CW-1:0]     cpu_push_count,
    input  logic              cpu_clear_req,
    output logic [CW-1:0]     cpu_used,
    output logic [CW-1:0]     cpu_free,
    input  logic              bus_pop,
    output logic [DW-1:0]     bus_rd_data,
    output logic [FL_NUM-1:0] irq_status,
    input  logic [FL_NUM-1:0] irq_clear
);

    logic          push_take, push_ok, flush;
    logic          ovf_ev, udf_ev, rde_ev;
    logic          wr_en, rd_en, pop_ok_q;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] size, count, count_nxt;
    logic [DW-1:0] mem_q;

    lram_fifo_seq #(.CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid   (cpu_push_valid),
        .push_last    (cpu_push_last),
        .clr_req      (cpu_clear_req),
        .push_ok      (push_ok),
        .push_take_o  (push_take),
        .push_ready_o (cpu_push_ready),
        .flush_o      (flush),
        .done_o       (cpu_push_done),
        .acc_o        (cpu_push_count)
    );

    lram_fifo_ptr #(
        .RAM_BYTES  (RAM_BYTES),
        .UNIT_BYTES (UNIT_BYTES),
        .AW         (AW),
        .UW         (UW),
        .CW         (CW)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_base   (cfg_fifo_base),
        .ram_base    (cfg_ram_base),
        .push_take   (push_take),
        .pop_req     (bus_pop),
        .flush       (flush),
        .size_o      (size),
        .count_o     (count),
        .count_nxt_o (count_nxt),
        .push_ok_o   (push_ok),
        .ovf_ev_o    (ovf_ev),
        .udf_ev_o    (udf_ev),
        .rde_ev_o    (rde_ev),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .pop_ok_q_o  (pop_ok_q)
    );

    lram_fifo_mem #(.DEPTH(RAM_BYTES), .AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (cpu_push_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (mem_q)
    );

    lram_fifo_irq #(.CW(CW)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_q   (count),
        .count_nxt (count_nxt),
        .low_mark  (cfg_low_mark),
        .ovf_ev    (ovf_ev),
        .udf_ev    (udf_ev),
        .rde_ev    (rde_ev),
        .clr_w1    (irq_clear),
        .status_o  (irq_status)
    );

    always_comb begin
        cpu_used    = count;
        cpu_free    = (size > count) ? (size - count) : '0;
        bus_rd_data = pop_ok_q ? mem_q : '0;
    end

    // R6: a pop on a zero-size window yields zero and the read-error flag
    p_rderr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_pop && (size == '0) && !flush) |=> ((bus_rd_data == '0) && irq_status[FL_RDERR]));

    // R10: the flush cycle leaves the queue empty
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cpu_used == '0));

endmodule

// File: tb/lram_fifo_tb_top.sv
module lram_fifo_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_fifo_base = 6'd0;
    logic [5:0] cfg_ram_base = 6'd2;
    logic [8:0] cfg_low_mark = 9'd0;
    logic       cpu_push_valid = 1'b0;
    logic       cpu_push_last = 1'b0;
    logic [7:0] cpu_push_data = 8'h00;
    logic       cpu_push_ready;
    logic       cpu_push_done;
    logic [8:0] cpu_push_count;
    logic       cpu_clear_req = 1'b0;
    logic [8:0] cpu_used;
    logic [8:0] cpu_free;
    logic       bus_pop = 1'b0;
    logic [7:0] bus_rd_data;
    logic [3:0] irq_status;
    logic [3:0] irq_clear = 4'h0;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lram_fifo dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_fifo_base  (cfg_fifo_base),
        .cfg_ram_base   (cfg_ram_base),
        .cfg_low_mark   (cfg_low_mark),
        .cpu_push_valid (cpu_push_valid),
        .cpu_push_last  (cpu_push_last),
        .cpu_push_data  (cpu_push_data),
        .cpu_push_ready (cpu_push_ready),
        .cpu_push_done  (cpu_push_done),
        .cpu_push_count (cpu_push_count),
        .cpu_clear_req  (cpu_clear_req),
        .cpu_used       (cpu_used),
        .cpu_free       (cpu_free),
        .bus_pop        (bus_pop),
        .bus_rd_data    (bus_rd_data),
        .irq_status     (irq_status),
        .irq_clear      (irq_clear)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one edge with the given strobes; outputs sampled 1 time unit after it
    task automatic xfer(input logic pv, input logic pl, input logic [7:0] pd,
                        input logic pp, output logic [7:0] rd);
        cpu_push_valid = pv;
        cpu_push_last  = pl;
        cpu_push_data  = pd;
        bus_pop        = pp;
        @(posedge clk);
        #1;
        cpu_push_valid = 1'b0;
        cpu_push_last  = 1'b0;
        bus_pop        = 1'b0;
        rd = bus_rd_data;
    endtask

    task automatic idle();
        logic [7:0] d;
        xfer(1'b0, 1'b0, 8'h00, 1'b0, d);
    endtask

    task automatic wclear(input logic [3:0] m);
        irq_clear = m;
        idle();
        irq_clear = 4'h0;
    endtask

    task automatic do_flush();
        cpu_clear_req = 1'b1;
        idle();
        cpu_clear_req = 1'b0;
        idle();
    endtask

    task automatic configure(input logic [5:0] fb, input logic [5:0] rb);
        cfg_fifo_base = fb;
        cfg_ram_base  = rb;
        do_flush();
    endtask

    task automatic push_burst(input int n, input logic [7:0] first, input int exp_acc,
                              input string tag);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            xfer(1'b1, (i == n - 1), first + 8'(i), 1'b0, d);
        end
        check({tag, " done"}, int'(cpu_push_done), 1);
        check({tag, " count"}, int'(cpu_push_count), exp_acc);
        idle();
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string tag);
        logic [7:0] d;
        xfer(1'b0, 1'b0, 8'h00, 1'b1, d);
        check(tag, int'(d), int'(exp));
    endtask

    task automatic pop_any();
        logic [7:0] d;
        xfer(1'b0, 1'b0, 8'h00, 1'b1, d);
    endtask

    task automatic t_reset();
        check("R1 used", int'(cpu_used), 0);
        check("R1 free", int'(cpu_free), 16);
        check("R1 status", int'(irq_status), 0);
        check("R1 ready", int'(cpu_push_ready), 1);
        check("R1 done", int'(cpu_push_done), 0);
    endtask

    task automatic t_order();
        configure(6'd2, 6'd4);
        check("R2 free size16", int'(cpu_free), 16);
        push_burst(5, 8'h10, 5, "R9 burst5");
        check("R2 used", int'(cpu_used), 5);
        check("R2 free", int'(cpu_free), 11);
        for (int i = 0; i < 5; i++) begin
            pop_expect(8'h10 + 8'(i), "R2 order");
        end
        check("R2 used drained", int'(cpu_used), 0);
    endtask

    task automatic t_report_ignore();
        logic [7:0] d;
        xfer(1'b1, 1'b1, 8'hA0, 1'b0, d);
        check("R9 done single", int'(cpu_push_done), 1);
        check("R9 count single", int'(cpu_push_count), 1);
        check("R9 ready low", int'(cpu_push_ready), 0);
        xfer(1'b1, 1'b0, 8'hA1, 1'b0, d);
        check("R9 done cleared", int'(cpu_push_done), 0);
        check("R9 report byte ignored", int'(cpu_used), 1);
        pop_expect(8'hA0, "R9 kept byte");
    endtask

    task automatic t_wrap();
        configure(6'd5, 6'd6);
        check("R3 free size8", int'(cpu_free), 8);
        for (int r = 0; r < 3; r++) begin
            push_burst(6, 8'(r * 16), 6, "R3 fill");
            for (int j = 0; j < 6; j++) begin
                pop_expect(8'(r * 16 + j), "R3 wrap order");
            end
        end
        check("R3 used", int'(cpu_used), 0);
    endtask

    task automatic t_overflow();
        configure(6'd5, 6'd6);
        wclear(4'hF);
        push_burst(10, 8'h40, 8, "R4 R9 burst over");
        check("R4 flag", int'(irq_status[1]), 1);
        check("R4 used", int'(cpu_used), 8);
        check("R4 free", int'(cpu_free), 0);
        for (int i = 0; i < 8; i++) begin
            pop_expect(8'h40 + 8'(i), "R4 kept data");
        end
        check("R4 dropped gone", int'(cpu_used), 0);
        wclear(4'h2);
        check("R8 clear ovf", int'(irq_status[1]), 0);
    endtask

    task automatic t_underflow();
        wclear(4'hF);
        pop_expect(8'h00, "R5 data");
        check("R5 status", int'(irq_status), 4'b0100);
        check("R5 used", int'(cpu_used), 0);
    endtask

    task automatic t_rderr();
        configure(6'd4, 6'd4);
        check("R2 free zero", int'(cpu_free), 0);
        wclear(4'hF);
        pop_expect(8'h00, "R6 data");
        check("R6 rderr", int'(irq_status[3]), 1);
        check("R6 no underflow", int'(irq_status[2]), 0);
        configure(6'd6, 6'd3);
        check("R2 reversed free", int'(cpu_free), 0);
        configure(6'd30, 6'd40);
        check("R2 clamp free", int'(cpu_free), 16);
        wclear(4'hF);
    endtask

    task automatic t_thresh();
        logic [7:0] d;
        configure(6'd2, 6'd4);
        cfg_low_mark = 9'd4;
        wclear(4'hF);
        push_burst(6, 8'h00, 6, "R7 fill");
        check("R7 rise no flag", int'(irq_status[0]), 0);
        pop_any();
        pop_any();
        check("R7 at mark", int'(irq_status[0]), 0);
        pop_any();
        check("R7 crossing", int'(irq_status[0]), 1);
        wclear(4'h1);
        check("R8 clear low", int'(irq_status[0]), 0);
        pop_any();
        check("R7 stays below", int'(irq_status[0]), 0);
        push_burst(3, 8'h00, 3, "R7 refill");
        check("R7 rising", int'(irq_status[0]), 0);
        pop_any();
        pop_any();
        check("R7 second crossing", int'(irq_status[0]), 1);
        wclear(4'h1);
        push_burst(1, 8'h00, 1, "R8 to mark");
        irq_clear = 4'h1;
        xfer(1'b0, 1'b0, 8'h00, 1'b1, d);
        irq_clear = 4'h0;
        check("R8 set wins", int'(irq_status[0]), 1);
        wclear(4'h1);
        push_burst(3, 8'h00, 3, "R10 pre flush");
        do_flush();
        check("R10 used", int'(cpu_used), 0);
        check("R10 free", int'(cpu_free), 16);
        check("R10 low on flush", int'(irq_status[0]), 1);
        cfg_low_mark = 9'd0;
        wclear(4'hF);
    endtask

    task automatic t_flush();
        logic [7:0] d;
        configure(6'd2, 6'd4);
        push_burst(3, 8'h20, 3, "R10 load");
        cpu_clear_req = 1'b1;
        idle();
        cpu_clear_req = 1'b0;
        check("R10 ready low", int'(cpu_push_ready), 0);
        xfer(1'b1, 1'b1, 8'h77, 1'b0, d);
        check("R10 flushed", int'(cpu_used), 0);
        check("R10 byte ignored done", int'(cpu_push_done), 0);
        pop_expect(8'h00, "R10 empty pop");
        check("R10 underflow", int'(irq_status[2]), 1);
        wclear(4'hF);
    endtask

    task automatic t_same();
        logic [7:0] d;
        configure(6'd5, 6'd6);
        wclear(4'hF);
        push_burst(2, 8'h50, 2, "R11 load");
        xfer(1'b1, 1'b1, 8'h52, 1'b1, d);
        check("R11 pair data", int'(d), 8'h50);
        check("R11 pair used", int'(cpu_used), 2);
        check("R11 pair count", int'(cpu_push_count), 1);
        idle();
        pop_expect(8'h51, "R11 after pair a");
        pop_expect(8'h52, "R11 after pair b");
        wclear(4'hF);
        xfer(1'b1, 1'b1, 8'h60, 1'b1, d);
        check("R11 empty data", int'(d), 0);
        check("R11 empty udf", int'(irq_status[2]), 1);
        check("R11 empty used", int'(cpu_used), 1);
        idle();
        pop_expect(8'h60, "R11 empty kept");
        push_burst(8, 8'h70, 8, "R11 fill");
        wclear(4'hF);
        xfer(1'b1, 1'b1, 8'h99, 1'b1, d);
        check("R11 full data", int'(d), 8'h70);
        check("R11 full ovf", int'(irq_status[1]), 1);
        check("R11 full used", int'(cpu_used), 7);
        check("R11 full count", int'(cpu_push_count), 0);
        idle();
        wclear(4'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_report_ignore();
        t_wrap();
        t_overflow();
        t_underflow();
        t_rderr();
        t_thresh();
        t_flush();
        t_same();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule